// File: doc/BRIEF.md
# Event-Tagged Cross-Point Router Buffer

This block is one crossing node of a parallel event builder. It sits where an input data bus meets an output farm bus. Every word on the data bus carries an event tag and a fragment-end flag. The node keeps only the words whose tag matches an event that the assignment manager has handed to this farm bus. Each kept word is written into its event's region of a dual-port buffer, so fragments of several events may arrive interleaved and in any order. Once an event has seen the expected number of fragment ends, the node replays it on the farm bus at that bus's own pace. It sends a header beat first, then the payload.

The data bus is a snooping tap: `in_valid` qualifies a word, and the node never pushes back on it. When a word cannot be stored, it is dropped and the loss is flagged; the bus is never held. The farm-bus output follows valid/ready rules. A beat transfers on a rising edge where both `out_valid` and `out_ready` are high. While `out_ready` is low, the offered beat is held unchanged. If the farm bus stays unready for a whole timeout window, the node gives up on that event, frees the slot and flags the stall. It does not block later events.

The assignment table has `SLOTS` entries. Each entry has a tag, a valid bit and an expected count of fragment ends, and each owns `DEPTH` words of the buffer.

Top module: `evt_router_node`

## Requirements
- R1: A data-bus word is stored only when its tag equals the tag of a valid slot that is not yet complete. Words with any other tag leave the output, `slot_busy` and both flag vectors unchanged. If two slots hold the same tag, the lowest-numbered slot takes the word.
- R2: When `cfg_we` is high on a clock edge, the slot `cfg_slot` is loaded with `cfg_tag`, `cfg_frags` and `cfg_valid`. The same load clears that slot's stored words, its fragment count, its overflow flag and its stall flag. `slot_busy[i]` reflects the slot's valid bit.
- R3: A slot becomes complete when it has seen `cfg_frags` words with `in_last` set. Later words carrying its tag are ignored.
- R4: Each output frame starts with a header beat. In the header, bits 31:24 hold the tag, bits 15:0 hold the stored word count, and all other bits are zero. The payload beats follow in arrival order. `out_last` is high on the final beat, which is the header itself when the count is zero.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` and `out_last` stay stable on the next cycle, unless the stall timeout fires.
- R6: Complete slots are sent one frame at a time, lowest slot index first. After the last beat transfers, the slot is freed and `slot_busy` clears.
- R7: A word for a slot that already holds `DEPTH` words is dropped, and `ovf_flags[slot]` is set and stays set. Its `in_last` still counts toward completion, and the frame carries only the stored words.
- R8: If `out_valid` is high with `out_ready` low for `STALL_CYC` consecutive cycles, the frame is abandoned. `out_valid` falls, the slot is freed, and `stall_flags[slot]` is set.
- R9: Fragments of different assigned events may interleave word by word. Each event's frame contains only its own words, in its own arrival order.
- R10: After reset, `out_valid` is low, and `slot_busy`, `ovf_flags` and `stall_flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load one assignment slot |
| cfg_slot | input | $clog2(SLOTS) | Slot index to load |
| cfg_valid | input | 1 | Valid bit written into the slot |
| cfg_tag | input | TW | Event tag assigned to the slot |
| cfg_frags | input | FW | Number of fragment ends that complete the event |
| in_valid | input | 1 | Data-bus word present |
| in_data | input | DW | Data-bus payload |
| in_tag | input | TW | Event tag of the word |
| in_last | input | 1 | Word ends a fragment |
| out_valid | output | 1 | Farm-bus beat offered |
| out_ready | input | 1 | Farm bus accepts the beat |
| out_data | output | DW | Header or payload beat |
| out_last | output | 1 | Final beat of the frame |
| slot_busy | output | SLOTS | Per-slot valid bits |
| ovf_flags | output | SLOTS | Sticky per-slot overflow flags |
| stall_flags | output | SLOTS | Sticky per-slot stall-abandon flags |

## Verification
The bench builds the node with four slots of eight words each and a stall window of sixteen cycles. With these values, a ten-word event overruns its region and a held-low ready line reaches the timeout quickly. Three events complete while one frame is waiting, which shows the lowest-slot-first order. Unassigned tags are mixed in with interleaved fragments. A late word is sent to an already complete event. A ready line that toggles tests the hold rule on held beats.

// File: rtl/evt_router_pkg.sv
package evt_router_pkg;
  typedef enum logic [1:0] {FR_IDLE, FR_HDR, FR_PAY} fr_state_t;
  localparam int HDR_CNT_W = 16;
endpackage

// File: rtl/evt_word_store.sv
module evt_word_store #(
  parameter int DW    = 32,
  parameter int WORDS = 256,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/evt_assign_tbl.sv
module evt_assign_tbl #(
  parameter int SLOTS = 8,
  parameter int DEPTH = 32,
  parameter int TW    = 8,
  parameter int FW    = 8,
  localparam int SW   = $clog2(SLOTS),
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [SW-1:0]             cfg_slot,
  input  logic                      cfg_valid,
  input  logic [TW-1:0]             cfg_tag,
  input  logic [FW-1:0]             cfg_frags,
  input  logic                      in_valid,
  input  logic [TW-1:0]             in_tag,
  input  logic                      in_last,
  input  logic                      rel_valid,
  input  logic [SW-1:0]             rel_slot,
  input  logic                      rel_stall,
  output logic                      wr_en,
  output logic [SW+AW-1:0]          wr_addr,
  output logic [SLOTS-1:0]          done,
  output logic [SLOTS-1:0][CW-1:0]  wcnt,
  output logic [SLOTS-1:0][TW-1:0]  tags,
  output logic [SLOTS-1:0]          busy,
  output logic [SLOTS-1:0]          ovf,
  output logic [SLOTS-1:0]          stall
);
  logic [SLOTS-1:0][FW-1:0] exp_q, seen_q;
  logic [SLOTS-1:0]         hit;
  logic [SW-1:0]            gi;
  logic                     any_hit, gi_full;

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      done[i] = busy[i] && (seen_q[i] == exp_q[i]);
      hit[i]  = in_valid && busy[i] && !done[i] && (tags[i] == in_tag);
    end
    any_hit = |hit;
    gi = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (hit[i]) gi = SW'(i);
    end
    gi_full = (wcnt[gi] == CW'(DEPTH));
    wr_en   = any_hit && !gi_full;
    wr_addr = {gi, wcnt[gi][AW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0; ovf <= '0; stall <= '0;
      tags <= '0; exp_q <= '0; seen_q <= '0; wcnt <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (cfg_we && cfg_slot == SW'(i)) begin
          busy[i]   <= cfg_valid;
          tags[i]   <= cfg_tag;
          exp_q[i]  <= cfg_frags;
          seen_q[i] <= '0;
          wcnt[i]   <= '0;
          ovf[i]    <= 1'b0;
          stall[i]  <= 1'b0;
        end else begin
          if (rel_valid && rel_slot == SW'(i)) begin
            busy[i] <= 1'b0;
            if (rel_stall) stall[i] <= 1'b1;
          end
          if (any_hit && gi == SW'(i)) begin
            if (gi_full) ovf[i] <= 1'b1;
            else         wcnt[i] <= wcnt[i] + CW'(1);
            if (in_last) seen_q[i] <= seen_q[i] + FW'(1);
          end
        end
      end
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_chk
    // R7
    ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf[g]) |-> $past(in_valid) && $past(wcnt[g]) == CW'(DEPTH));
    // R6
    slot_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[g]) |-> $past(cfg_we && cfg_slot == SW'(g)) ||
                         $past(rel_valid && rel_slot == SW'(g)));
  end
endmodule

// File: rtl/evt_out_framer.sv
module evt_out_framer
  import evt_router_pkg::*;
#(
  parameter int SLOTS     = 8,
  parameter int DEPTH     = 32,
  parameter int DW        = 32,
  parameter int TW        = 8,
  parameter int STALL_CYC = 64,
  localparam int SW  = $clog2(SLOTS),
  localparam int AW  = $clog2(DEPTH),
  localparam int CW  = AW + 1,
  localparam int STW = $clog2(STALL_CYC + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SLOTS-1:0]          done,
  input  logic [SLOTS-1:0][CW-1:0]  wcnt,
  input  logic [SLOTS-1:0][TW-1:0]  tags,
  output logic [SW+AW-1:0]          rd_addr,
  input  logic [DW-1:0]             rd_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [DW-1:0]             out_data,
  output logic                      out_last,
  output logic                      rel_valid,
  output logic [SW-1:0]             rel_slot,
  output logic                      rel_stall
);
  fr_state_t      st;
  logic [SW-1:0]  sel, pick;
  logic [CW-1:0]  idx, cnt;
  logic [STW-1:0] scnt;
  logic           fire, drop;

  always_comb begin
    pick = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (done[i]) pick = SW'(i);
    end
    cnt       = wcnt[sel];
    rd_addr   = {sel, idx[AW-1:0]};
    out_valid = (st != FR_IDLE);
    if (st == FR_HDR) begin
      out_data = {tags[sel], (DW-TW-HDR_CNT_W)'(0), HDR_CNT_W'(cnt)};
      out_last = (cnt == '0);
    end else begin
      out_data = rd_data;
      out_last = (st == FR_PAY) && (idx == cnt - CW'(1));
    end
    fire      = out_valid && out_ready;
    drop      = out_valid && !out_ready && (scnt == STW'(STALL_CYC - 1));
    rel_valid = (fire && out_last) || drop;
    rel_stall = drop;
    rel_slot  = sel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= FR_IDLE; sel <= '0; idx <= '0; scnt <= '0;
    end else begin
      case (st)
        FR_IDLE: if (|done) begin
          sel <= pick; idx <= '0; scnt <= '0; st <= FR_HDR;
        end
        default: begin
          if (drop) begin
            st <= FR_IDLE;
          end else if (fire) begin
            scnt <= '0;
            if (out_last) st <= FR_IDLE;
            else if (st == FR_HDR) st <= FR_PAY;
            else idx <= idx + CW'(1);
          end else begin
            scnt <= scnt + STW'(1);
          end
        end
      endcase
    end
  end

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !drop |=> out_valid && $stable(out_data) && $stable(out_last));
  // R4
  out_last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
endmodule

// File: rtl/evt_router_node.sv
module evt_router_node #(
  parameter int SLOTS     = 8,
  parameter int DEPTH     = 32,
  parameter int DW        = 32,
  parameter int TW        = 8,
  parameter int FW        = 8,
  parameter int STALL_CYC = 64,
  localparam int SW = $clog2(SLOTS),
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SW-1:0]    cfg_slot,
  input  logic             cfg_valid,
  input  logic [TW-1:0]    cfg_tag,
  input  logic [FW-1:0]    cfg_frags,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  input  logic [TW-1:0]    in_tag,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             out_last,
  output logic [SLOTS-1:0] slot_busy,
  output logic [SLOTS-1:0] ovf_flags,
  output logic [SLOTS-1:0] stall_flags
);
  logic                     wr_en, rel_valid, rel_stall;
  logic [SW+AW-1:0]         wr_addr, rd_addr;
  logic [SW-1:0]            rel_slot;
  logic [DW-1:0]            rd_data;
  logic [SLOTS-1:0]         done;
  logic [SLOTS-1:0][CW-1:0] wcnt;
  logic [SLOTS-1:0][TW-1:0] tags;

  evt_assign_tbl #(.SLOTS(SLOTS), .DEPTH(DEPTH), .TW(TW), .FW(FW)) tbl_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_valid(cfg_valid),
    .cfg_tag(cfg_tag), .cfg_frags(cfg_frags),
    .in_valid(in_valid), .in_tag(in_tag), .in_last(in_last),
    .rel_valid(rel_valid), .rel_slot(rel_slot), .rel_stall(rel_stall),
    .wr_en(wr_en), .wr_addr(wr_addr), .done(done), .wcnt(wcnt), .tags(tags),
    .busy(slot_busy), .ovf(ovf_flags), .stall(stall_flags)
  );

  evt_word_store #(.DW(DW), .WORDS(SLOTS * DEPTH)) store_i (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(in_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  evt_out_framer #(.SLOTS(SLOTS), .DEPTH(DEPTH), .DW(DW), .TW(TW),
                   .STALL_CYC(STALL_CYC)) framer_i (
    .clk(clk), .rst_n(rst_n), .done(done), .wcnt(wcnt), .tags(tags),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .rel_valid(rel_valid), .rel_slot(rel_slot),
    .rel_stall(rel_stall)
  );
endmodule

// File: tb/evt_router_node_tb.sv
module evt_router_node_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 4;
  localparam int DEPTH = 8;
  localparam int STALL = 16;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_valid = 0;
  logic [1:0] cfg_slot = 0;
  logic [7:0] cfg_tag = 0, cfg_frags = 0;
  logic in_valid = 0, in_last = 0;
  logic [31:0] in_data = 0;
  logic [7:0] in_tag = 0;
  logic out_valid, out_ready = 0, out_last;
  logic [31:0] out_data;
  logic [SLOTS-1:0] slot_busy, ovf_flags, stall_flags;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] expq [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_router_node #(.SLOTS(SLOTS), .DEPTH(DEPTH), .STALL_CYC(STALL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_valid(cfg_valid), .cfg_tag(cfg_tag), .cfg_frags(cfg_frags),
    .in_valid(in_valid), .in_data(in_data), .in_tag(in_tag), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .slot_busy(slot_busy), .ovf_flags(ovf_flags),
    .stall_flags(stall_flags)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      report();
    end
  end

  task automatic load(input int slot, input logic [7:0] tg, input int frags, input bit v);
    @(negedge clk);
    cfg_we = 1; cfg_slot = 2'(slot); cfg_tag = tg; cfg_frags = 8'(frags); cfg_valid = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input logic [7:0] tg, input logic [31:0] d, input bit last);
    @(negedge clk);
    in_valid = 1; in_tag = tg; in_data = d; in_last = last;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; in_last = 0;
  endtask

  // Collects one frame; payload expected in expq[0..n-1].
  task automatic recv(input logic [7:0] tg, input int n, input bit toggle, input string req);
    int beat = 0, guard = 0;
    bit held_v = 0;
    logic [31:0] held = 0;
    while (beat <= n && guard < 200) begin
      @(negedge clk);
      guard++;
      out_ready = toggle ? (guard % 3 != 0) : 1'b1;
      if (out_valid) begin
        if (held_v) chk(out_data == held, {req, " R5 hold"}, out_data, held);
        if (out_ready) begin
          if (beat == 0) begin
            chk(out_data == {tg, 8'h00, 16'(n)}, {req, " R4 header"}, out_data, {tg, 8'h00, 16'(n)});
            chk(out_last == (n == 0), {req, " R4 last"}, 32'(out_last), 32'(n == 0));
          end else begin
            chk(out_data == expq[beat-1], {req, " R4 payload"}, out_data, expq[beat-1]);
            chk(out_last == (beat == n), {req, " R4 last"}, 32'(out_last), 32'(beat == n));
          end
          beat++;
          held_v = 0;
        end else begin
          held = out_data; held_v = 1;
        end
      end
    end
    chk(beat == n + 1, {req, " frame complete"}, 32'(beat), 32'(n + 1));
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 0, "R10 out_valid", 32'(out_valid), 0);
    chk(slot_busy == 0, "R10 busy", 32'(slot_busy), 0);
    chk(ovf_flags == 0 && stall_flags == 0, "R10 flags", {ovf_flags, stall_flags}, 0);
  endtask

  task automatic t_basic();
    load(0, 8'h11, 1, 1);
    chk(slot_busy == 4'b0001, "R2 busy after load", 32'(slot_busy), 1);
    send(8'h22, 32'hdead0000, 1);
    send(8'h11, 32'h11000001, 0);
    send(8'h22, 32'hdead0001, 0);
    send(8'h11, 32'h11000002, 0);
    send(8'h11, 32'h11000003, 1);
    idle();
    expq[0] = 32'h11000001; expq[1] = 32'h11000002; expq[2] = 32'h11000003;
    recv(8'h11, 3, 0, "R1 basic");
    @(negedge clk);
    chk(slot_busy == 0, "R6 freed", 32'(slot_busy), 0);
    chk(out_valid == 0, "R1 unassigned ignored", 32'(out_valid), 0);
  endtask

  task automatic t_interleave();
    load(0, 8'h30, 1, 1);
    load(1, 8'h31, 2, 1);
    load(2, 8'h32, 1, 1);
    send(8'h30, 32'ha0, 1);
    send(8'h31, 32'hb0, 0);
    send(8'h55, 32'hee, 1);
    send(8'h32, 32'hc0, 0);
    send(8'h31, 32'hb1, 1);
    send(8'h32, 32'hc1, 1);
    send(8'h30, 32'haf, 1);
    send(8'h31, 32'hb2, 1);
    idle();
    expq[0] = 32'ha0;
    recv(8'h30, 1, 0, "R3 late word ignored");
    expq[0] = 32'hb0; expq[1] = 32'hb1; expq[2] = 32'hb2;
    recv(8'h31, 3, 1, "R6 R9 lowest slot next");
    expq[0] = 32'hc0; expq[1] = 32'hc1;
    recv(8'h32, 2, 1, "R9 interleaved");
    @(negedge clk);
    chk(slot_busy == 0, "R6 all freed", 32'(slot_busy), 0);
  endtask

  task automatic t_overflow();
    load(0, 8'h40, 1, 1);
    for (int k = 0; k < 10; k++) begin
      send(8'h40, 32'h40000000 + 32'(k), k == 9);
      if (k < 8) expq[k] = 32'h40000000 + 32'(k);
    end
    idle();
    chk(ovf_flags == 4'b0001, "R7 overflow flag", 32'(ovf_flags), 1);
    recv(8'h40, 8, 0, "R7 truncated frame");
    @(negedge clk);
    chk(ovf_flags == 4'b0001, "R7 flag sticky", 32'(ovf_flags), 1);
    load(0, 8'h41, 1, 1);
    chk(ovf_flags == 0, "R2 reload clears overflow", 32'(ovf_flags), 0);
    send(8'h41, 32'h41414141, 1);
    idle();
    expq[0] = 32'h41414141;
    recv(8'h41, 1, 0, "R2 reloaded slot");
  endtask

  task automatic t_stall();
    load(3, 8'h60, 1, 1);
    send(8'h60, 32'h60606060, 1);
    idle();
    out_ready = 0;
    repeat (30) @(negedge clk);
    chk(out_valid == 0, "R8 frame dropped", 32'(out_valid), 0);
    chk(slot_busy == 0, "R8 slot freed", 32'(slot_busy), 0);
    chk(stall_flags == 4'b1000, "R8 stall flag", 32'(stall_flags), 32'h8);
    send(8'h60, 32'h60600001, 1);
    idle();
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && slot_busy == 0, "R1 freed tag ignored", {out_valid, slot_busy}, 0);
    load(3, 8'h61, 2, 1);
    chk(stall_flags == 0, "R2 reload clears stall", 32'(stall_flags), 0);
    load(3, 8'h61, 2, 0);
    chk(slot_busy == 0, "R2 valid bit clear", 32'(slot_busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_interleave();
    t_overflow();
    t_stall();
    report();
  end
endmodule